// File: doc/BRIEF.md
# Unaligned Load Merge Unit

This block carries out the two partial-word loads that a 32-bit big-endian core uses to fetch a word that does not sit on a four-byte boundary. A command gives a byte address, a side select (left or right) and the current contents of the destination register. The unit makes one read of the aligned word that holds the addressed byte. It then writes a variable number of bytes from that word into one end of the register value and leaves the other bytes as they were.

A left load is given the address of the most significant byte of the wanted value and fills the upper end of the register. A right load is given the address of the least significant byte and fills the lower end. A left load at address A followed by a right load at A+3 into the same register builds the whole unaligned word. Neither load ever touches a second memory word, so an unaligned access needs no fault.

Commands come in on a valid/ready pair. The memory side is a request valid/ready pair followed by a single-cycle response strobe, arriving one or more cycles later. The merged word comes back with a one-cycle done strobe.

Top module: `ulm_merge_unit`

## Requirements
- R1: `cmd_ready` is high while the unit is idle and in the cycle that carries the result, and low otherwise. A command is accepted when `cmd_valid` and `cmd_ready` are both high, and it captures `cmd_side`, `cmd_addr` and `cmd_reg_val`. A command accepted in the result cycle is served in full and does not alter the result shown in that cycle.
- R2: Each accepted command produces exactly one memory request. The request address is `cmd_addr` with its two low bits forced to zero, and `mem_req_valid` and the address stay unchanged until `mem_req_ready` is high.
- R3: From the cycle after acceptance until the response, `cmd_ready` stays low. `res_valid` is high for exactly one cycle: the cycle after `mem_rsp_valid` is seen while a request is outstanding.
- R4: With `cmd_side` = 0 (left) and offset o = `cmd_addr[1:0]`, register bytes 0 to 3-o take memory bytes o to 3 in that order. Bytes are numbered most significant first, so byte k occupies bits [31-8k:24-8k] in both the register and the memory word.
- R5: With `cmd_side` = 1 (right) and offset o, register bytes 3-o to 3 take memory bytes 0 to o in that order, with the same numbering as R4.
- R6: Register bytes that a load does not write appear in `res_data` with their captured `cmd_reg_val` values.
- R7: A left load at offset 0 replaces the whole register. A left load at offset 3 replaces only the most significant byte.
- R8: A right load at offset 0 replaces only the least significant byte. A right load at offset 3 replaces the whole register.
- R9: A left load at address A, followed by a right load at A+3 that takes the first result as its register value, returns the big-endian word made of memory bytes A to A+3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | A command is offered |
| cmd_ready | output | 1 | The unit can take a command this cycle |
| cmd_side | input | 1 | 0 = left load, 1 = right load |
| cmd_addr | input | 32 | Effective byte address |
| cmd_reg_val | input | 32 | Current destination register value |
| mem_req_valid | output | 1 | Aligned word read requested |
| mem_req_ready | input | 1 | Memory accepts the request |
| mem_req_addr | output | 32 | Word-aligned read address |
| mem_rsp_valid | input | 1 | Read data present this cycle |
| mem_rsp_data | input | 32 | Read word, byte 0 in the top bits |
| res_valid | output | 1 | One-cycle done strobe |
| res_data | output | 32 | Merged register value |

## Verification
The result cycle and the acceptance of the next command can fall in the same cycle, because `cmd_ready` is raised while the done strobe is shown. The bench provokes this by offering the next command at the very edge after the response. It first samples the finished result and `cmd_ready`, and then drives the new command. The outgoing result is judged against the reference for the old command. The new command is judged by a full request, response and merge of its own, with its captured register value intact.

// File: rtl/ulm_pkg.sv
package ulm_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_REQ  = 2'd1,
    ST_WAIT = 2'd2,
    ST_DONE = 2'd3
  } ulm_state_e;

  typedef enum logic {
    SIDE_LEFT  = 1'b0,
    SIDE_RIGHT = 1'b1
  } ulm_side_e;

endpackage

// File: rtl/ulm_cmd_ctrl.sv
module ulm_cmd_ctrl
  import ulm_pkg::*;
#(
  parameter int AW = 32,
  parameter int DW = 32,
  localparam int NB = DW / 8,
  localparam int OW = $clog2(NB)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cmd_valid,
  input  logic          cmd_side,
  input  logic [AW-1:0] cmd_addr,
  input  logic [DW-1:0] cmd_reg_val,
  output logic          cmd_ready,
  output logic          mem_req_valid,
  input  logic          mem_req_ready,
  output logic [AW-1:0] mem_req_addr,
  input  logic          mem_rsp_valid,
  output logic          rsp_fire,
  output ulm_side_e     side_q,
  output logic [OW-1:0] off_q,
  output logic [DW-1:0] reg_q
);

  ulm_state_e       state_q, state_d;
  logic [AW-OW-1:0] word_q;
  logic             cmd_fire;
  logic             req_fire;

  assign cmd_ready     = (state_q == ST_IDLE) || (state_q == ST_DONE);
  assign cmd_fire      = cmd_valid && cmd_ready;
  assign mem_req_valid = (state_q == ST_REQ);
  assign req_fire      = mem_req_valid && mem_req_ready;
  assign rsp_fire      = (state_q == ST_WAIT) && mem_rsp_valid;
  assign mem_req_addr  = {word_q, {OW{1'b0}}};

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE: if (cmd_fire) state_d = ST_REQ;
      ST_REQ:  if (req_fire) state_d = ST_WAIT;
      ST_WAIT: if (rsp_fire) state_d = ST_DONE;
      ST_DONE: state_d = cmd_fire ? ST_REQ : ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      word_q  <= '0;
      off_q   <= '0;
      side_q  <= SIDE_LEFT;
      reg_q   <= '0;
    end else begin
      state_q <= state_d;
      if (cmd_fire) begin
        word_q <= cmd_addr[AW-1:OW];
        off_q  <= cmd_addr[OW-1:0];
        side_q <= ulm_side_e'(cmd_side);
        reg_q  <= cmd_reg_val;
      end
    end
  end

  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && !mem_req_ready) |=> (mem_req_valid && $stable(mem_req_addr))); // R2

  AST_BUSY_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_fire |=> !cmd_ready); // R3

endmodule

// File: rtl/ulm_byte_merge.sv
module ulm_byte_merge
  import ulm_pkg::*;
#(
  parameter int DW = 32,
  localparam int NB = DW / 8,
  localparam int OW = $clog2(NB)
) (
  input  ulm_side_e     side,
  input  logic [OW-1:0] off,
  input  logic [DW-1:0] reg_val,
  input  logic [DW-1:0] mem_word,
  output logic [DW-1:0] merged
);

  // Lane 0 is the most significant byte, both in the register and in memory.
  function automatic logic lane_written(ulm_side_e s, logic [OW-1:0] o, int lane);
    int edge_lane;
    edge_lane = NB - 1 - int'(o);
    if (s == SIDE_RIGHT) return lane >= edge_lane;
    return lane <= edge_lane;
  endfunction

  function automatic logic [OW-1:0] lane_source(ulm_side_e s, logic [OW-1:0] o, int lane);
    int src;
    if (s == SIDE_RIGHT) src = lane - (NB - 1 - int'(o));
    else                 src = lane + int'(o);
    return OW'(src);
  endfunction

  for (genvar g = 0; g < NB; g++) begin : g_lane
    logic [OW-1:0] src_lane;
    logic          take_mem;
    logic [7:0]    mem_byte;

    assign take_mem = lane_written(side, off, g);
    assign src_lane = lane_source(side, off, g);
    assign mem_byte = mem_word[DW-1-8*int'(src_lane) -: 8];
    assign merged[DW-1-8*g -: 8] = take_mem ? mem_byte : reg_val[DW-1-8*g -: 8];
  end

endmodule

// File: rtl/ulm_result_reg.sv
module ulm_result_reg #(
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [DW-1:0] merged,
  output logic          res_valid,
  output logic [DW-1:0] res_data
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_valid <= 1'b0;
      res_data  <= '0;
    end else begin
      res_valid <= load;
      if (load) res_data <= merged;
    end
  end

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |=> !res_valid); // R3

endmodule

// File: rtl/ulm_merge_unit.sv
module ulm_merge_unit
  import ulm_pkg::*;
#(
  parameter int AW = 32,
  parameter int DW = 32,
  localparam int NB = DW / 8,
  localparam int OW = $clog2(NB)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cmd_valid,
  output logic          cmd_ready,
  input  logic          cmd_side,
  input  logic [AW-1:0] cmd_addr,
  input  logic [DW-1:0] cmd_reg_val,
  output logic          mem_req_valid,
  input  logic          mem_req_ready,
  output logic [AW-1:0] mem_req_addr,
  input  logic          mem_rsp_valid,
  input  logic [DW-1:0] mem_rsp_data,
  output logic          res_valid,
  output logic [DW-1:0] res_data
);

  logic          rsp_fire;
  ulm_side_e     side_q;
  logic [OW-1:0] off_q;
  logic [DW-1:0] reg_q;
  logic [DW-1:0] merged;

  ulm_cmd_ctrl #(.AW(AW), .DW(DW)) ctrl_i (
    .clk           (clk),
    .rst_n         (rst_n),
    .cmd_valid     (cmd_valid),
    .cmd_side      (cmd_side),
    .cmd_addr      (cmd_addr),
    .cmd_reg_val   (cmd_reg_val),
    .cmd_ready     (cmd_ready),
    .mem_req_valid (mem_req_valid),
    .mem_req_ready (mem_req_ready),
    .mem_req_addr  (mem_req_addr),
    .mem_rsp_valid (mem_rsp_valid),
    .rsp_fire      (rsp_fire),
    .side_q        (side_q),
    .off_q         (off_q),
    .reg_q         (reg_q)
  );

  ulm_byte_merge #(.DW(DW)) merge_i (
    .side     (side_q),
    .off      (off_q),
    .reg_val  (reg_q),
    .mem_word (mem_rsp_data),
    .merged   (merged)
  );

  ulm_result_reg #(.DW(DW)) result_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (rsp_fire),
    .merged    (merged),
    .res_valid (res_valid),
    .res_data  (res_data)
  );

  AST_NO_ACCEPT_WHILE_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid |-> !cmd_ready); // R3

  AST_LEFT_FULL_AT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && side_q == SIDE_LEFT && off_q == '0) |-> res_data == $past(mem_rsp_data)); // R7

  AST_LEFT_KEEP_AT_LAST: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && side_q == SIDE_LEFT && off_q == OW'(NB-1)) |-> res_data[DW-9:0] == reg_q[DW-9:0]); // R7

  AST_RIGHT_FULL_AT_LAST: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && side_q == SIDE_RIGHT && off_q == OW'(NB-1)) |-> res_data == $past(mem_rsp_data)); // R8

  AST_RIGHT_KEEP_AT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && side_q == SIDE_RIGHT && off_q == '0) |-> res_data[DW-1:8] == reg_q[DW-1:8]); // R8

endmodule

// File: tb/ulm_merge_unit_tb_top.sv
module ulm_merge_unit_tb_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cmd_valid = 1'b0;
  logic        cmd_ready;
  logic        cmd_side = 1'b0;
  logic [31:0] cmd_addr = '0;
  logic [31:0] cmd_reg_val = '0;
  logic        mem_req_valid;
  logic        mem_req_ready = 1'b0;
  logic [31:0] mem_req_addr;
  logic        mem_rsp_valid = 1'b0;
  logic [31:0] mem_rsp_data = '0;
  logic        res_valid;
  logic [31:0] res_data;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  logic [7:0] mem_b [16];

  always #10 clk = ~clk;

  ulm_merge_unit dut_i (
    .clk           (clk),
    .rst_n         (rst_n),
    .cmd_valid     (cmd_valid),
    .cmd_ready     (cmd_ready),
    .cmd_side      (cmd_side),
    .cmd_addr      (cmd_addr),
    .cmd_reg_val   (cmd_reg_val),
    .mem_req_valid (mem_req_valid),
    .mem_req_ready (mem_req_ready),
    .mem_req_addr  (mem_req_addr),
    .mem_rsp_valid (mem_rsp_valid),
    .mem_rsp_data  (mem_rsp_data),
    .res_valid     (res_valid),
    .res_data      (res_data)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] word_at(int base);
    return {mem_b[base], mem_b[base+1], mem_b[base+2], mem_b[base+3]};
  endfunction

  // Reference: walk the register byte by byte, most significant first.
  function automatic logic [31:0] ref_merge(bit right, int addr, logic [31:0] regv);
    logic [7:0] r [4];
    int o, base;
    o = addr % 4;
    base = addr - o;
    for (int i = 0; i < 4; i++) r[i] = regv[31-8*i -: 8];
    if (!right) begin
      for (int i = 0; o + i < 4; i++) r[i] = mem_b[base + o + i];
    end else begin
      for (int k = 0; k <= o; k++) r[3 - o + k] = mem_b[base + k];
    end
    return {r[0], r[1], r[2], r[3]};
  endfunction

  function automatic logic [31:0] keep_mask(bit right, int addr);
    logic [31:0] m;
    int o;
    o = addr % 4;
    m = '0;
    for (int i = 0; i < 4; i++) begin
      if (!right && i > 3 - o) m[31-8*i -: 8] = 8'hFF;
      if (right && i < 3 - o)  m[31-8*i -: 8] = 8'hFF;
    end
    return m;
  endfunction

  // Starts at a negedge; returns at the negedge of the result cycle.
  task automatic run_load(input bit right, input int addr, input logic [31:0] regv,
                          input int stall, input int lat, output logic [31:0] got);
    int base;
    base = addr - (addr % 4);
    cmd_valid = 1'b1;
    cmd_side = right;
    cmd_addr = 32'(addr);
    cmd_reg_val = regv;
    while (!cmd_ready) @(negedge clk);
    @(negedge clk);
    cmd_valid = 1'b0;
    cmd_reg_val = ~regv;
    chk("R3 result strobe cleared after acceptance", {31'd0, res_valid}, 32'd0);
    for (int s = 0; s < stall; s++) begin
      chk("R2 request held while stalled", {31'd0, mem_req_valid}, 32'd1);
      chk("R3 busy while request pending", {31'd0, cmd_ready}, 32'd0);
      @(negedge clk);
    end
    chk("R2 request valid", {31'd0, mem_req_valid}, 32'd1);
    chk("R2 aligned request address", mem_req_addr, 32'(base));
    mem_req_ready = 1'b1;
    @(negedge clk);
    mem_req_ready = 1'b0;
    chk("R2 single request", {31'd0, mem_req_valid}, 32'd0);
    for (int w = 1; w < lat; w++) begin
      chk("R3 busy while waiting", {31'd0, cmd_ready}, 32'd0);
      chk("R3 no early result", {31'd0, res_valid}, 32'd0);
      @(negedge clk);
    end
    mem_rsp_valid = 1'b1;
    mem_rsp_data = word_at(base);
    @(negedge clk);
    mem_rsp_valid = 1'b0;
    mem_rsp_data = $urandom;
    chk("R3 result strobe", {31'd0, res_valid}, 32'd1);
    chk("R1 ready in result cycle", {31'd0, cmd_ready}, 32'd1);
    got = res_data;
  endtask

  task automatic judge(input bit right, input int addr, input logic [31:0] regv, input logic [31:0] got);
    logic [31:0] exp, km;
    int o;
    o = addr % 4;
    exp = ref_merge(right, addr, regv);
    km = keep_mask(right, addr);
    if (!right) chk("R4 left merge", got, exp);
    else        chk("R5 right merge", got, exp);
    chk("R6 unwritten bytes kept", got & km, regv & km);
    if (!right && (o == 0 || o == 3)) chk("R7 left edge offset", got, exp);
    if (right && (o == 0 || o == 3))  chk("R8 right edge offset", got, exp);
  endtask

  initial begin
    logic [31:0] got, first;
    for (int i = 0; i < 16; i++) mem_b[i] = 8'($urandom);
    for (int i = 0; i < 4; i++) mem_b[i] = 8'(i);
    repeat (3) @(negedge clk);
    chk("R1 ready after reset", {31'd0, cmd_ready}, 32'd1);
    chk("R2 no request after reset", {31'd0, mem_req_valid}, 32'd0);
    chk("R3 no result after reset", {31'd0, res_valid}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);

    // Worked example: memory bytes 00..03, register AA BB CC DD.
    run_load(1'b1, 2, 32'hAABBCCDD, 0, 1, got);
    chk("R5 right at offset 2", got, 32'hAA000102);
    @(negedge clk);
    chk("R3 strobe lasts one cycle", {31'd0, res_valid}, 32'd0);
    run_load(1'b0, 2, 32'hAABBCCDD, 1, 2, got);
    chk("R4 left at offset 2", got, 32'h0203CCDD);
    @(negedge clk);

    // Sweep both sides, every offset, every word, two register patterns.
    for (int side = 0; side < 2; side++) begin
      for (int a = 0; a < 16; a++) begin
        for (int p = 0; p < 2; p++) begin
          logic [31:0] rv;
          rv = (p == 0) ? 32'($urandom) : 32'h5A5A_A5A5 ^ 32'(a);
          run_load(side[0], a, rv, int'($urandom_range(0, 2)), int'($urandom_range(1, 3)), got);
          judge(side[0], a, rv, got);
          // Odd p: next command offered in the result cycle (R1 overlap).
          if (p == 0) begin
            @(negedge clk);
            chk("R3 strobe lasts one cycle", {31'd0, res_valid}, 32'd0);
          end
        end
      end
    end
    @(negedge clk);

    // Left then right pairs assemble the unaligned word.
    for (int a = 0; a < 13; a++) begin
      logic [31:0] rv;
      rv = $urandom;
      run_load(1'b0, a, rv, int'($urandom_range(0, 1)), int'($urandom_range(1, 2)), first);
      run_load(1'b1, a + 3, first, 0, 1, got);
      chk("R9 left/right pair", got,
          {mem_b[a], mem_b[a+1], mem_b[a+2], mem_b[a+3]});
      if (a % 2 == 0) @(negedge clk);
    end

    @(negedge clk);
    if (!finished) begin
      finished = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++;
      errors++;
      $display("FAIL watchdog actual=hung expected=complete");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule